// File: doc/BRIEF.md
# Floating-Point Register Stack with Slot Tags

This block holds the operand registers of a floating-point unit as an eight-slot circular stack. A rotating top pointer selects which physical slot is the current top, and every other operand is named by its distance from the top. Each slot is 80 bits wide and is kept as two separate fields: a 64-bit mantissa and a 16-bit exponent. Each slot also carries a 2-bit tag that says what the slot holds. The tag records whether the slot is empty, so stack overflow and underflow are detected from the tags alone, with no occupancy counter.

One request is accepted per cycle, and there are four kinds. A push moves the top down by one and fills the new top. A pop empties the top and moves the top up by one. A read checks that a relative operand is present. A write replaces a relative operand. Read data for the operand named by `idx_i` is always available combinationally. When a value is written, the block classifies it and stores the result as the slot's tag.

A request that would overflow or underflow the stack is rejected and leaves all state unchanged. A one-cycle fault pulse reports the rejection.

Top module: `fpu_reg_stack`

## Requirements
- R1: After reset, `top_o` is 0, every tag is 11 (empty), and `fault_o` is 0.
- R2: `tag_word_o` packs the tag of physical slot k into bits [2k+1:2k], so slot 7 is in the top pair and slot 0 in the bottom pair.
- R3: A push (`op_i` = 2'b00) that does not fault sets `top_o` to (top - 1) mod 8 and stores the write data and its class tag in that slot.
- R4: A push faults when the slot at (top - 1) mod 8 is not empty.
- R5: A pop (`op_i` = 2'b01) that does not fault sets the tag of the current top slot to 11 and sets `top_o` to (top + 1) mod 8.
- R6: A pop faults when the top slot is empty. A read (`op_i` = 2'b10) faults when slot (top + `idx_i`) mod 8 is empty.
- R7: A faulting request changes neither `top_o` nor `tag_word_o`.
- R8: Relative operand i maps to physical slot (top + i) mod 8. The outputs `rd_mant_o`, `rd_exp_o` and `rd_tag_o` show that slot for i = `idx_i`, and a write targets it.
- R9: A stored value gets tag 10 when its exponent is all ones, tag 01 when both exponent and mantissa are zero, and tag 00 otherwise.
- R10: A write (`op_i` = 2'b11) never faults, even into an empty slot. It replaces the data and tag of its target and leaves `top_o` unchanged.
- R11: `fault_o` is high for exactly the one cycle after a faulting request and is low after any request that does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 push, 01 pop, 10 read, 11 write |
| idx_i | input | 3 | Relative operand index for read, write and read data |
| wr_mant_i | input | MANT_W | Mantissa for push and write |
| wr_exp_i | input | EXP_W | Exponent for push and write |
| rd_mant_o | output | MANT_W | Mantissa of operand `idx_i` |
| rd_exp_o | output | EXP_W | Exponent of operand `idx_i` |
| rd_tag_o | output | 2 | Tag of operand `idx_i` |
| top_o | output | 3 | Physical index of the top slot |
| tag_word_o | output | 16 | Packed tags of all slots |
| fault_o | output | 1 | Stack fault, registered |

## Verification
The bench keeps the stack depth at eight but narrows the mantissa to 8 bits and the exponent to 4 bits. At these widths the value classifier can be swept over all 4096 exponent and mantissa pairs through ordinary writes. Filling the stack to the ninth push and draining it to the ninth pop drives the top pointer through every value and around its wrap in both directions. A long random mix of requests is then compared against an arithmetic model of the pointer and tags, which reaches faults at every relative offset.

// File: rtl/fpu_stk_pkg.sv
package fpu_stk_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    OP_PUSH  = 2'b00,
    OP_POP   = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } op_e;
endpackage

// File: rtl/fpu_stk_classify.sv
module fpu_stk_classify
  import fpu_stk_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output tag_e              tag_o
);
  always_comb begin
    if (&exp_i)                   tag_o = TAG_SPECIAL;
    else if (exp_i == '0 && mant_i == '0) tag_o = TAG_ZERO;
    else                          tag_o = TAG_VALID;
  end
endmodule

// File: rtl/fpu_stk_regfile.sv
module fpu_stk_regfile #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = 3,
  parameter int MANT_W   = 64,
  parameter int EXP_W    = 16
) (
  input  logic                clk_i,
  input  logic [NUM_REGS-1:0] wr_en_i,
  input  logic [MANT_W-1:0]   wr_mant_i,
  input  logic [EXP_W-1:0]    wr_exp_i,
  input  logic [PTR_W-1:0]    rd_slot_i,
  output logic [MANT_W-1:0]   rd_mant_o,
  output logic [EXP_W-1:0]    rd_exp_o
);
  logic [MANT_W-1:0] mant_q [NUM_REGS];
  logic [EXP_W-1:0]  exp_q  [NUM_REGS];

  // mantissa and exponent kept on separate paths
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i[g]) begin
        mant_q[g] <= wr_mant_i;
        exp_q[g]  <= wr_exp_i;
      end
    end
  end

  assign rd_mant_o = mant_q[rd_slot_i];
  assign rd_exp_o  = exp_q[rd_slot_i];
endmodule

// File: rtl/fpu_stk_ctrl.sv
module fpu_stk_ctrl
  import fpu_stk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_valid_i,
  input  logic [1:0]            op_i,
  input  logic [PTR_W-1:0]      idx_i,
  input  tag_e                  new_tag_i,
  output logic [PTR_W-1:0]      top_o,
  output logic [2*NUM_REGS-1:0] tag_word_o,
  output logic [1:0]            rd_tag_o,
  output logic [PTR_W-1:0]      rd_slot_o,
  output logic [NUM_REGS-1:0]   wr_en_o,
  output logic                  fault_o
);
  logic [PTR_W-1:0] top_q, st_slot, push_slot, tgt_slot;
  tag_e             tags_q [NUM_REGS];
  tag_e             tgt_tag;
  op_e              op;
  logic             fault_c, accept, is_push, is_pop, is_read, is_write;

  assign op        = op_e'(op_i);
  assign is_push   = op_valid_i && op == OP_PUSH;
  assign is_pop    = op_valid_i && op == OP_POP;
  assign is_read   = op_valid_i && op == OP_READ;
  assign is_write  = op_valid_i && op == OP_WRITE;

  assign st_slot   = top_q + idx_i;
  assign push_slot = top_q - 1'b1;

  always_comb begin
    if (is_push)     tgt_slot = push_slot;
    else if (is_pop) tgt_slot = top_q;
    else             tgt_slot = st_slot;
  end

  assign tgt_tag = tags_q[tgt_slot];
  assign fault_c = (is_push && tgt_tag != TAG_EMPTY)
                || ((is_pop || is_read) && tgt_tag == TAG_EMPTY);
  assign accept  = op_valid_i && !fault_c;

  always_comb begin
    wr_en_o = '0;
    if (accept && (is_push || is_write)) wr_en_o[tgt_slot] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q   <= '0;
      fault_o <= 1'b0;
      for (int k = 0; k < NUM_REGS; k++) tags_q[k] <= TAG_EMPTY;
    end else begin
      fault_o <= fault_c;
      if (accept) begin
        if (is_push) begin
          top_q            <= push_slot;
          tags_q[tgt_slot] <= new_tag_i;
        end else if (is_pop) begin
          tags_q[top_q]    <= TAG_EMPTY;
          top_q            <= top_q + 1'b1;
        end else if (is_write) begin
          tags_q[tgt_slot] <= new_tag_i;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pack
    assign tag_word_o[2*g +: 2] = tags_q[g];
  end

  assign top_o     = top_q;
  assign rd_slot_o = st_slot;
  assign rd_tag_o  = tags_q[st_slot];

  assert_push_moves_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_push && !fault_c) |=> top_o == PTR_W'($past(top_o) - 1'b1));

  assert_pop_empties_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pop && !fault_c) |=> (tags_q[$past(top_o)] == TAG_EMPTY)
                             && top_o == PTR_W'($past(top_o) + 1'b1));

  assert_fault_keeps_state_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(top_o) && $stable(tag_word_o)));

  assert_fault_follows_request_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(op_valid_i) && $past(op_i) != OP_WRITE);

  assert_single_slot_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));

  assert_write_no_top_move_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_write |=> $stable(top_o));
endmodule

// File: rtl/fpu_reg_stack.sv
module fpu_reg_stack
  import fpu_stk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int MANT_W   = 64,
  parameter int EXP_W    = 16,
  localparam int PTR_W   = $clog2(NUM_REGS),
  localparam int TW_W    = 2 * NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic [PTR_W-1:0]  idx_i,
  input  logic [MANT_W-1:0] wr_mant_i,
  input  logic [EXP_W-1:0]  wr_exp_i,
  output logic [MANT_W-1:0] rd_mant_o,
  output logic [EXP_W-1:0]  rd_exp_o,
  output logic [1:0]        rd_tag_o,
  output logic [PTR_W-1:0]  top_o,
  output logic [TW_W-1:0]   tag_word_o,
  output logic              fault_o
);
  tag_e                new_tag;
  logic [NUM_REGS-1:0] wr_en;
  logic [PTR_W-1:0]    rd_slot;

  fpu_stk_classify #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_classify (
    .mant_i (wr_mant_i),
    .exp_i  (wr_exp_i),
    .tag_o  (new_tag)
  );

  fpu_stk_ctrl #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .idx_i      (idx_i),
    .new_tag_i  (new_tag),
    .top_o      (top_o),
    .tag_word_o (tag_word_o),
    .rd_tag_o   (rd_tag_o),
    .rd_slot_o  (rd_slot),
    .wr_en_o    (wr_en),
    .fault_o    (fault_o)
  );

  fpu_stk_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .MANT_W(MANT_W),
                    .EXP_W(EXP_W)) u_regfile (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_mant_i (wr_mant_i),
    .wr_exp_i  (wr_exp_i),
    .rd_slot_i (rd_slot),
    .rd_mant_o (rd_mant_o),
    .rd_exp_o  (rd_exp_o)
  );
endmodule

// File: tb/fpu_reg_stack_tb_top.sv
`timescale 1ns/1ps
module fpu_reg_stack_tb_top;
  localparam int MW = 8;
  localparam int EW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [2:0]    idx_i = '0;
  logic [MW-1:0] wr_mant_i = '0;
  logic [EW-1:0] wr_exp_i = '0;
  logic [MW-1:0] rd_mant_o;
  logic [EW-1:0] rd_exp_o;
  logic [1:0]    rd_tag_o;
  logic [2:0]    top_o;
  logic [15:0]   tag_word_o;
  logic          fault_o;

  int checks = 0;
  int fails  = 0;

  int            m_top;
  int            m_tag [8];
  logic [MW-1:0] m_mant [8];
  logic [EW-1:0] m_exp  [8];

  always #5 clk_i = ~clk_i;

  fpu_reg_stack #(.NUM_REGS(8), .MANT_W(MW), .EXP_W(EW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int classify(input logic [MW-1:0] m, input logic [EW-1:0] e);
    if (&e) return 2;
    if (e == 0 && m == 0) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = m_tag[k][1:0];
    return w;
  endfunction

  task automatic model_reset();
    m_top = 0;
    for (int k = 0; k < 8; k++) m_tag[k] = 3;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(input int op, input int idx, input logic [MW-1:0] m,
                        input logic [EW-1:0] e, input string req);
    int  slot;
    bit  xf = 0;
    case (op)
      0: begin
        slot = (m_top + 7) % 8;
        if (m_tag[slot] != 3) xf = 1;
        else begin m_top = slot; m_tag[slot] = classify(m, e); m_mant[slot] = m; m_exp[slot] = e; end
      end
      1: begin
        if (m_tag[m_top] == 3) xf = 1;
        else begin m_tag[m_top] = 3; m_top = (m_top + 1) % 8; end
      end
      2: begin
        if (m_tag[(m_top + idx) % 8] == 3) xf = 1;
      end
      default: begin
        slot = (m_top + idx) % 8;
        m_tag[slot] = classify(m, e); m_mant[slot] = m; m_exp[slot] = e;
      end
    endcase
    op_valid_i = 1'b1; op_i = 2'(op); idx_i = 3'(idx);
    wr_mant_i = m; wr_exp_i = e;
    @(posedge clk_i);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk(fault_o == xf, req, "fault", fault_o, xf);
    chk(top_o == 3'(m_top), req, "top", top_o, m_top);
    chk(tag_word_o == exp_word(), req, "tag word", tag_word_o, exp_word());
  endtask

  task automatic check_read(input int idx, input string req);
    int slot;
    idx_i = 3'(idx);
    #1;
    slot = (m_top + idx) % 8;
    chk(rd_tag_o == 2'(m_tag[slot]), req, "rd tag", rd_tag_o, m_tag[slot]);
    if (m_tag[slot] != 3) begin
      chk(rd_mant_o == m_mant[slot], req, "rd mant", rd_mant_o, m_mant[slot]);
      chk(rd_exp_o == m_exp[slot], req, "rd exp", rd_exp_o, m_exp[slot]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(top_o == 0, "R1", "top", top_o, 0);
    chk(tag_word_o == 16'hFFFF, "R1", "tags", tag_word_o, 16'hFFFF);
    chk(fault_o == 0, "R1", "fault", fault_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 pop and read on empty stack
    run_op(1, 0, 0, 0, "R6");
    run_op(2, 5, 0, 0, "R6");

    // R3 fill, R2 packing checked per push; mix of classes
    for (int k = 0; k < 8; k++)
      run_op(0, 0, (k == 2) ? 8'h00 : 8'(8'h11 * k + 1), (k == 2) ? 4'h0 : ((k == 5) ? 4'hF : 4'(k)), "R3");
    chk(top_o == 0, "R3", "wrap top", top_o, 0);
    // R4 ninth push faults, R7 holds state, R11 pulse width
    run_op(0, 0, 8'h55, 4'h3, "R4");
    @(negedge clk_i);
    chk(fault_o == 0, "R11", "fault drop", fault_o, 0);

    // R8 relative read mapping
    for (int i = 0; i < 8; i++) check_read(i, "R8");
    for (int i = 0; i < 8; i++) run_op(2, i, 0, 0, "R8");

    // R5 drain, then R6 ninth pop
    for (int k = 0; k < 8; k++) begin
      check_read(0, "R5");
      run_op(1, 0, 0, 0, "R5");
    end
    run_op(1, 0, 0, 0, "R6");

    // R10 write into empty slot does not fault
    run_op(3, 3, 8'hA5, 4'h6, "R10");
    check_read(3, "R10");
    run_op(1, 0, 0, 0, "R6");

    // R9 exhaustive classification at ST(0)
    run_op(0, 0, 8'h01, 4'h1, "R3");
    for (int e = 0; e < 16; e++)
      for (int m = 0; m < 256; m++) begin
        run_op(3, 0, 8'(m), 4'(e), "R9");
        chk(rd_tag_o == 2'(classify(8'(m), 4'(e))), "R9", "class",
            rd_tag_o, classify(8'(m), 4'(e)));
      end

    // R7 random mix with faults at every offset
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 3);
      int ix = $urandom_range(0, 7);
      run_op(op, ix, 8'($urandom), 4'($urandom), "R7");
      check_read(ix, "R8");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule